// File: doc/BRIEF.md
# Daisy-Chained Auto-Configuration Unit

This block is the power-up configuration logic of one expansion card. After reset the card is unconfigured and does not respond to anything. When the upstream card (or the host, for the first slot) raises this card's chain input, the card starts listening: reads inside a fixed 64 KB configuration window return its descriptor, one 4-bit nibble per 16-bit word. The descriptor holds the board type, the memory-size code and a product identifier. Only the card whose chain input is high answers, so two boards never share the window, whichever slots they sit in.

System software reads the descriptor and then writes the card's base address as two nibble writes. The upper-nibble write completes configuration. The card leaves the window, decodes its normal space at the assigned base, and raises its chain output so the next board can be configured. Software may instead write a shut-up offset. The card then goes permanently silent and still passes the chain on. Bus cycles are reduced to single-cycle read and write strobes.

Top module: `autocfg_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chain_out, rd_valid, rd_data and card_sel are all 0.
- R2: While chain_in is low in the unconfigured state, reads of the window give rd_valid 0 and writes to it have no effect: chain_out stays 0 and a later listening read still returns the descriptor.
- R3: While listening (chain_in high), a read strobe (without a write strobe) to window address WIN_BASE+off gives rd_valid=1 and rd_data one cycle later. For even off 0, 2, 4 and 6, rd_data[15:12] is, in order, BOARD_TYPE, {0,SIZE_CODE}, PROD_ID[7:4] and PROD_ID[3:0]. rd_data[11:0] is 0. Any other offset returns data 0 with rd_valid=1.
- R4: A listening write to offset 0x48 stores wr_data[15:12] as base address bits 19:16. The write does not complete configuration: chain_out stays 0 and window reads are still answered.
- R5: A listening write to offset 0x4A stores wr_data[15:12] as base bits 23:20 and completes configuration. From the next cycle chain_out is 1 and window reads are no longer answered.
- R6: When configured, card_sel is high in the same cycle as a read or write strobe whose address matches the base in the bits compared for the size.
- R7: Size code 0 selects 8 MB and compares addr[23] only. Code k from 1 to 7 selects 64 KB·2^(k-1) and compares addr[23:15+k].
- R8: A listening write to offset 0x4C makes the card silent. From the next cycle chain_out is 1, card_sel never rises and window reads are not answered.
- R9: If chain_in falls before configuration completes, window reads in that cycle and later get no response until chain_in rises again and one idle cycle passes.
- R10: Once configured or silent, the card ignores chain_in and all further writes: the base and chain_out do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_in | input | 1 | Configuration enable from the previous card |
| chain_out | output | 1 | Configuration enable to the next card |
| addr | input | 24 | Byte address of the current access |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_data | input | 16 | Write data; bits 15:12 carry the nibble |
| rd_valid | output | 1 | Window read response, one cycle after the strobe |
| rd_data | output | 16 | Window read data |
| card_sel | output | 1 | Normal-space decode hit, same cycle as the strobe |

## Verification
A wrong state shows within one cycle. A card stuck unconfigured keeps answering window reads and never raises chain_out. A card that leaves the window too early raises chain_out after the low-nibble write. A base or size fault shows only as card_sel at the wrong addresses, so the bench probes both edges of the decoded region for a small size and for the 8 MB size. Silent and configured states differ only in card_sel. They are therefore told apart by accesses inside the assigned region.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE       = 2'd0,
      ST_LISTEN     = 2'd1,
      ST_CONFIGURED = 2'd2,
      ST_SILENT     = 2'd3
   } acfg_state_t;

   // Lowest address bit compared against the base for a given size code.
   function automatic int size_low_bit(input int code, input int addr_w, input int win_bits);
      if (code == 0) return addr_w - 1;
      return win_bits - 1 + code;
   endfunction

endpackage

// File: rtl/acfg_desc.sv
module acfg_desc #(
   parameter int          WIN_BITS   = 16,
   parameter int          NIB_W      = 4,
   parameter int          DESC_NIBS  = 4,
   parameter logic [3:0]  BOARD_TYPE = 4'hC,
   parameter logic [2:0]  SIZE_CODE  = 3'd3,
   parameter logic [7:0]  PROD_ID    = 8'h5A
) (
   input  logic [WIN_BITS-1:0] off,
   output logic [NIB_W-1:0]    nib
);
   localparam int IDX_W = (DESC_NIBS > 1) ? $clog2(DESC_NIBS) : 1;

   logic [NIB_W-1:0] rom [DESC_NIBS];

   function automatic logic [NIB_W-1:0] entry(input int k);
      case (k)
         0:       return NIB_W'(BOARD_TYPE);
         1:       return NIB_W'({1'b0, SIZE_CODE});
         2:       return NIB_W'(PROD_ID[7:4]);
         3:       return NIB_W'(PROD_ID[3:0]);
         default: return '0;
      endcase
   endfunction

   for (genvar k = 0; k < DESC_NIBS; k++) begin : g_rom
      assign rom[k] = entry(k);
   end

   logic [WIN_BITS-2:0] word_idx;
   logic                in_range;

   assign word_idx = off[WIN_BITS-1:1];
   assign in_range = !off[0] && (word_idx < (WIN_BITS-1)'(DESC_NIBS));

   always_comb begin
      nib = '0;
      if (in_range) nib = rom[word_idx[IDX_W-1:0]];
   end
endmodule

// File: rtl/acfg_ctrl.sv
module acfg_ctrl
   import acfg_pkg::*;
#(
   parameter int               WIN_BITS = 16,
   parameter int               NIB_W    = 4,
   parameter int               BASE_W   = 8,
   parameter logic [15:0]      BASE_OFF = 16'h0048,
   parameter logic [15:0]      SHUT_OFF = 16'h004C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                chain_in,
   input  logic                wr_en,
   input  logic [WIN_BITS-1:0] off,
   input  logic [NIB_W-1:0]    wnib,
   output acfg_state_t         state,
   output logic [BASE_W-1:0]   base
);
   localparam int BASE_NIBS = BASE_W / NIB_W;
   localparam logic [WIN_BITS-1:0] LAST_OFF = WIN_BITS'(BASE_OFF + 16'(2 * (BASE_NIBS - 1)));

   acfg_state_t state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:   if (chain_in) state_nx = ST_LISTEN;
         ST_LISTEN: begin
            if (!chain_in)                               state_nx = ST_IDLE;
            else if (wr_en && off == WIN_BITS'(SHUT_OFF)) state_nx = ST_SILENT;
            else if (wr_en && off == LAST_OFF)           state_nx = ST_CONFIGURED;
         end
         default:   state_nx = state;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   for (genvar k = 0; k < BASE_NIBS; k++) begin : g_base
      localparam logic [WIN_BITS-1:0] OFF_K = WIN_BITS'(BASE_OFF + 16'(2 * k));
      always_ff @(posedge clk) begin
         if (!rst_n)
            base[k*NIB_W +: NIB_W] <= '0;
         else if (wr_en && off == OFF_K)
            base[k*NIB_W +: NIB_W] <= wnib;
      end
   end
endmodule

// File: rtl/acfg_match.sv
module acfg_match
   import acfg_pkg::*;
#(
   parameter int         ADDR_W    = 24,
   parameter int         WIN_BITS  = 16,
   parameter int         BASE_W    = 8,
   parameter logic [2:0] SIZE_CODE = 3'd3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BASE_W-1:0] base,
   output logic              hit
);
   localparam int LO = size_low_bit(int'(SIZE_CODE), ADDR_W, WIN_BITS);

   if (LO == ADDR_W - 1) begin : g_single
      assign hit = (addr[ADDR_W-1] == base[BASE_W-1]);
   end else begin : g_slice
      assign hit = (addr[ADDR_W-1:LO] == base[BASE_W-1:LO-WIN_BITS]);
   end
endmodule

// File: rtl/autocfg_unit.sv
module autocfg_unit
   import acfg_pkg::*;
#(
   parameter int          ADDR_W     = 24,
   parameter int          DATA_W     = 16,
   parameter int          WIN_BITS   = 16,
   parameter int          NIB_W      = 4,
   parameter logic [23:0] WIN_BASE   = 24'hE8_0000,
   parameter logic [3:0]  BOARD_TYPE = 4'hC,
   parameter logic [2:0]  SIZE_CODE  = 3'd3,
   parameter logic [7:0]  PROD_ID    = 8'h5A,
   parameter logic [15:0] BASE_OFF   = 16'h0048,
   parameter logic [15:0] SHUT_OFF   = 16'h004C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chain_in,
   output logic              chain_out,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              card_sel
);
   localparam int BASE_W    = ADDR_W - WIN_BITS;
   localparam int DESC_NIBS = 4;

   if (ADDR_W != 24) begin : g_bad_addr
      $error("autocfg_unit: ADDR_W must be 24");
   end
   if (BASE_W % NIB_W != 0) begin : g_bad_nib
      $error("autocfg_unit: base width must be a whole number of nibbles");
   end
   if (DATA_W < NIB_W) begin : g_bad_data
      $error("autocfg_unit: data bus narrower than a nibble");
   end

   acfg_state_t         state;
   logic [BASE_W-1:0]   base;
   logic [WIN_BITS-1:0] off;
   logic [NIB_W-1:0]    desc_nib;
   logic                win_hit, listen, wr_en, rd_hit, base_hit;

   assign off     = addr[WIN_BITS-1:0];
   assign win_hit = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
   assign listen  = (state == ST_LISTEN) && chain_in;
   assign wr_en   = listen && wr_stb && win_hit;
   assign rd_hit  = listen && rd_stb && !wr_stb && win_hit;

   acfg_desc #(
      .WIN_BITS(WIN_BITS), .NIB_W(NIB_W), .DESC_NIBS(DESC_NIBS),
      .BOARD_TYPE(BOARD_TYPE), .SIZE_CODE(SIZE_CODE), .PROD_ID(PROD_ID)
   ) u_desc (
      .off(off), .nib(desc_nib)
   );

   acfg_ctrl #(
      .WIN_BITS(WIN_BITS), .NIB_W(NIB_W), .BASE_W(BASE_W),
      .BASE_OFF(BASE_OFF), .SHUT_OFF(SHUT_OFF)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .wr_en(wr_en),
      .off(off), .wnib(wr_data[DATA_W-1 -: NIB_W]),
      .state(state), .base(base)
   );

   acfg_match #(
      .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_W(BASE_W), .SIZE_CODE(SIZE_CODE)
   ) u_match (
      .addr(addr), .base(base), .hit(base_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_hit;
         rd_data  <= rd_hit ? {desc_nib, {(DATA_W-NIB_W){1'b0}}} : '0;
      end
   end

   assign chain_out = (state == ST_CONFIGURED) || (state == ST_SILENT);
   assign card_sel  = (state == ST_CONFIGURED) && (rd_stb || wr_stb) && base_hit;
endmodule

// File: rtl/acfg_checker.sv
module acfg_checker
   import acfg_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        chain_in,
   input logic        chain_out,
   input logic        rd_stb,
   input logic        wr_stb,
   input logic        rd_valid,
   input logic [15:0] rd_data,
   input logic        card_sel,
   input logic        wr_en,
   input logic [15:0] off,
   input acfg_state_t state,
   input logic [7:0]  base
);
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!chain_out && !rd_valid));

   a_r3_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(state) == ST_LISTEN && $past(chain_in) && $past(rd_stb) && !$past(wr_stb)));

   a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[11:0] == 12'h000);

   a_r5_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == 16'h004A) |=> chain_out);

   a_r6_sel_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      card_sel |-> ((rd_stb || wr_stb) && chain_out));

   a_r8_silent_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SILENT) |-> !card_sel);

   a_r10_chain_held: assert property (@(posedge clk) disable iff (!rst_n)
      chain_out |=> chain_out);

   a_r10_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(chain_out) && chain_out) |-> $stable(base));
endmodule

bind autocfg_unit acfg_checker u_acfg_checker (
   .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .chain_out(chain_out),
   .rd_stb(rd_stb), .wr_stb(wr_stb), .rd_valid(rd_valid), .rd_data(rd_data),
   .card_sel(card_sel), .wr_en(wr_en), .off(off), .state(state), .base(base)
);

// File: tb/autocfg_unit_test.sv
module autocfg_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chain_in = 1'b0;
   logic [23:0] addr = '0;
   logic        rd_stb = 1'b0, wr_stb = 1'b0;
   logic [15:0] wr_data = '0;

   logic        co [2];
   logic        rv [2];
   logic [15:0] rdd [2];
   logic        sel [2];

   int tests = 0, fails = 0;
   string phase = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   autocfg_unit #(.SIZE_CODE(3'd3)) uut (
      .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .chain_out(co[0]),
      .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_valid(rv[0]), .rd_data(rdd[0]), .card_sel(sel[0]));

   autocfg_unit #(.SIZE_CODE(3'd0)) uut_big (
      .clk(clk), .rst_n(rst_n), .chain_in(chain_in), .chain_out(co[1]),
      .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_valid(rv[1]), .rd_data(rdd[1]), .card_sel(sel[1]));

   // Reference model: 0 idle, 1 listening, 2 configured, 3 silent
   int          m_st [2] = '{0, 0};
   logic [7:0]  m_base [2] = '{8'h00, 8'h00};
   logic        m_rv [2] = '{1'b0, 1'b0};
   logic [15:0] m_rd [2] = '{16'h0, 16'h0};
   int          m_sc [2] = '{3, 0};

   function automatic logic [3:0] m_nib(input int i, input logic [15:0] o);
      if (o[0] || o > 16'h6) return 4'h0;
      case (o[3:1])
         3'd0: return 4'hC;
         3'd1: return 4'(m_sc[i]);
         3'd2: return 4'h5;
         default: return 4'hA;
      endcase
   endfunction

   function automatic logic m_sel(input int i);
      int lo;
      lo = (m_sc[i] == 0) ? 23 : 15 + m_sc[i];
      return (m_st[i] == 2) && (rd_stb || wr_stb) &&
             ((32'(addr) >> lo) == (32'(m_base[i]) >> (lo - 16)));
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (!rst_n) begin
            m_st[i] = 0; m_base[i] = 8'h00; m_rv[i] = 1'b0; m_rd[i] = 16'h0;
         end else begin
            logic win, lis;
            win = (addr[23:16] == 8'hE8);
            lis = (m_st[i] == 1) && chain_in;
            m_rv[i] = lis && rd_stb && !wr_stb && win;
            m_rd[i] = m_rv[i] ? {m_nib(i, addr[15:0]), 12'h000} : 16'h0;
            case (m_st[i])
               0: if (chain_in) m_st[i] = 1;
               1: if (!chain_in) m_st[i] = 0;
                  else if (wr_stb && win) begin
                     if (addr[15:0] == 16'h0048) m_base[i][3:0] = wr_data[15:12];
                     else if (addr[15:0] == 16'h004A) begin
                        m_base[i][7:4] = wr_data[15:12];
                        m_st[i] = 2;
                     end else if (addr[15:0] == 16'h004C) m_st[i] = 3;
                  end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      for (int i = 0; i < 2; i++) begin
         chk($sformatf("u%0d rd_valid", i), 16'(rv[i]), 16'(m_rv[i]));
         chk($sformatf("u%0d rd_data", i), rdd[i], m_rd[i]);
         chk($sformatf("u%0d chain_out", i), 16'(co[i]), 16'(m_st[i] >= 2));
         chk($sformatf("u%0d card_sel", i), 16'(sel[i]), 16'(m_sel(i)));
      end
   endtask

   task automatic step(input logic [23:0] a, input logic r, input logic w,
                       input logic [15:0] d, input logic ci);
      @(negedge clk);
      compare_all();
      addr = a; rd_stb = r; wr_stb = w; wr_data = d; chain_in = ci;
   endtask

   task automatic rd(input logic [23:0] a, input logic ci); step(a, 1'b1, 1'b0, 16'h0, ci); endtask
   task automatic wr(input logic [23:0] a, input logic [15:0] d, input logic ci); step(a, 1'b0, 1'b1, d, ci); endtask
   task automatic idle(input logic ci); step(24'h0, 1'b0, 1'b0, 16'h0, ci); endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) idle(1'b0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      phase = "R1"; do_reset(); idle(1'b0); idle(1'b0);

      phase = "R2";
      for (int k = 0; k < 8; k += 2) rd(24'hE8_0000 + 24'(k), 1'b0);
      wr(24'hE8_004A, 16'h7000, 1'b0);
      wr(24'hE8_004C, 16'h0000, 1'b0);
      idle(1'b0); idle(1'b0);

      phase = "R3";
      idle(1'b1);
      for (int k = 0; k < 10; k++) rd(24'hE8_0000 + 24'(k), 1'b1);
      rd(24'hE8_0100, 1'b1); rd(24'hE9_0000, 1'b1);
      step(24'hE8_0000, 1'b1, 1'b1, 16'h0, 1'b1);
      idle(1'b1);

      phase = "R9";
      rd(24'hE8_0000, 1'b0); rd(24'hE8_0002, 1'b0);
      rd(24'hE8_0000, 1'b1); rd(24'hE8_0000, 1'b1); idle(1'b1);

      phase = "R4";
      wr(24'hE8_0048, 16'h4000, 1'b1);
      rd(24'hE8_0002, 1'b1); rd(24'h24_0000, 1'b1); idle(1'b1);

      phase = "R5";
      wr(24'hE8_004A, 16'h2000, 1'b1);
      rd(24'hE8_0000, 1'b1); idle(1'b1);

      phase = "R6";
      rd(24'h24_0000, 1'b1); wr(24'h25_1234, 16'hFFFF, 1'b1);
      idle(1'b1); rd(24'h90_0000, 1'b1); rd(24'hE8_0000, 1'b1);

      phase = "R7";
      rd(24'h23_FFFE, 1'b1); rd(24'h27_FFFE, 1'b1); rd(24'h28_0000, 1'b1);
      rd(24'h7F_FFFE, 1'b1); rd(24'h80_0000, 1'b1); rd(24'h00_0000, 1'b1);

      phase = "R10";
      wr(24'hE8_004A, 16'h9000, 1'b1); wr(24'hE8_0048, 16'h1000, 1'b1);
      wr(24'hE8_004C, 16'h0000, 1'b1);
      idle(1'b0); rd(24'h24_0000, 1'b0); rd(24'h91_0000, 1'b0); idle(1'b0);

      phase = "R8";
      do_reset(); idle(1'b1); idle(1'b1);
      wr(24'hE8_0048, 16'h4000, 1'b1);
      wr(24'hE8_004C, 16'h0000, 1'b1);
      rd(24'hE8_0000, 1'b1); rd(24'h04_0000, 1'b1); rd(24'h00_0000, 1'b1);
      wr(24'hE8_004A, 16'h0000, 1'b1); rd(24'h00_0000, 1'b0); idle(1'b0);

      finish_run();
   end
endmodule